// File: doc/BRIEF.md
# MMU Control Register File and TLB Flush Decoder

This block is the software-visible control side of a 32-bit memory management unit. A processor reaches it through an alternate-space load/store port: each access carries an 8-bit space identifier, a 32-bit address and, for stores, a 32-bit data word. Space 4 selects a bank of sixteen 32-bit registers. Among them are a control word, a context number, a fault status word and a fault address. Space 3 carries maintenance commands. A store there is a TLB flush. A load there is a translation probe, which is handed to an external table walker.

Flush requests leave the block as one-cycle pulses. A page flush carries the virtual page number. A full flush has no operand. The block also raises a full flush by itself whenever software changes the control word or the context. A probe holds its request toward the walker until the walker reports a result. The load response is released only then, and no new access is accepted while the probe is outstanding. The fault status and fault address registers are loaded from a fault capture input. Software cannot write them.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset all sixteen registers read 0, and rvalid_o, busy_o, probe_req_o, flush_page_o and flush_all_o are low.
- R2: A load on space 4 returns the register selected by address bits 11:8 on rdata_o, with rvalid_o high for one cycle, in the cycle after the load is accepted.
- R3: A store to register 0 (control) changes only bit 0 (translation enable) and bit 1 (no-fault mode). Bits 31:2 keep their previous value.
- R4: A store that changes the value of register 0 or register 2 (context) produces a one-cycle flush_all_o pulse in the next cycle. A store that leaves the value unchanged produces no pulse.
- R5: Stores to register 3 (fault status) and register 4 (fault address) have no effect. A store to any other index except 0 writes the whole data word.
- R6: A fault_log_i pulse loads fault_stat_i into register 3 and fault_addr_i into register 4. A load of register 3 returns its value and clears it to 0. If a fault is logged in the same cycle, the new fault value is kept instead of 0.
- R7: A store on space 3 whose level field (address bits 11:8) is 0 produces a one-cycle flush_page_o pulse in the next cycle, with flush_vpn_o equal to address bits 31:12.
- R8: A store on space 3 with a level of 1 to 4 produces a one-cycle flush_all_o pulse. A level above 4 produces no flush.
- R9: A load on space 3 with a level of 0 to 4 raises probe_req_o in the next cycle, with probe_addr_o set to the full address and probe_level_o set to the level. The request is held until probe_valid_i is sampled high. In the cycle after that, rvalid_o is high with probe_data_i on rdata_o. A level above 4 returns 0 in the next cycle and raises no request.
- R10: A load on any space other than 3 or 4 returns 0 in the next cycle. A store on such a space changes no register and causes no flush.
- R11: While a probe is outstanding, busy_o is high and rd_i and wr_i are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| asi_i | input | 8 | Address space of the access |
| addr_i | input | 32 | Access address |
| wdata_i | input | 32 | Store data |
| rd_i | input | 1 | Load strobe |
| wr_i | input | 1 | Store strobe |
| rdata_o | output | 32 | Load data, valid with rvalid_o |
| rvalid_o | output | 1 | Load response pulse |
| busy_o | output | 1 | Probe outstanding; accesses are ignored |
| flush_page_o | output | 1 | Single-page flush pulse |
| flush_vpn_o | output | 20 | Page number for flush_page_o |
| flush_all_o | output | 1 | Full TLB flush pulse |
| probe_req_o | output | 1 | Probe request to the walker |
| probe_addr_o | output | 32 | Probed address |
| probe_level_o | output | 4 | Probe level |
| probe_valid_i | input | 1 | Walker result valid |
| probe_data_i | input | 32 | Walker result |
| fault_log_i | input | 1 | Capture a fault |
| fault_stat_i | input | 32 | Fault status to capture |
| fault_addr_i | input | 32 | Fault address to capture |

## Verification
The assertions assume that rd_i and wr_i are never high in the same cycle. They also assume that the walker raises probe_valid_i only in response to a held request. The stimulus therefore issues one strobe at a time and pulses probe_valid_i only after a probe has been started, with zero to several idle cycles of walker latency in between. Some accesses are deliberately aimed at busy periods to exercise R11. These cases rely on the block dropping them, not on the environment holding them back.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
  localparam int unsigned ASI_W    = 8;
  localparam int unsigned IDX_LSB  = 8;
  localparam int unsigned PAGE_LSB = 12;

  localparam logic [ASI_W-1:0] ASI_MAINT = 8'h03;
  localparam logic [ASI_W-1:0] ASI_REGS  = 8'h04;

  localparam int REG_CTRL  = 0;
  localparam int REG_CTX   = 2;
  localparam int REG_FSTAT = 3;
  localparam int REG_FADDR = 4;

  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_NF_BIT = 1;

  localparam int unsigned LVL_MAX = 4;

  typedef enum logic {PR_IDLE, PR_WAIT} probe_st_e;
endpackage

// File: rtl/mmu_reg_file.sv
module mmu_reg_file
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fault_log_i,
  input  logic [DATA_W-1:0] fault_stat_i,
  input  logic [DATA_W-1:0] fault_addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              chg_o
);
  localparam int unsigned NREG = 1 << IDX_W;
  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'((1 << CTRL_EN_BIT) | (1 << CTRL_NF_BIT));

  logic [NREG-1:0][DATA_W-1:0] regs_q, regs_d;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == REG_CTRL) begin : g_ctrl
      logic hit;
      assign hit = wr_en_i && (idx_i == IDX_W'(g));
      assign regs_d[g] = hit ? ((regs_q[g] & ~CTRL_MASK) | (wdata_i & CTRL_MASK)) : regs_q[g];
    end else if (g == REG_FSTAT) begin : g_fstat
      logic rd_hit;
      assign rd_hit = rd_en_i && (idx_i == IDX_W'(g));
      // a new fault wins over the clear-on-read
      assign regs_d[g] = fault_log_i ? fault_stat_i : (rd_hit ? '0 : regs_q[g]);
    end else if (g == REG_FADDR) begin : g_faddr
      assign regs_d[g] = fault_log_i ? fault_addr_i : regs_q[g];
    end else begin : g_plain
      logic hit;
      assign hit = wr_en_i && (idx_i == IDX_W'(g));
      assign regs_d[g] = hit ? wdata_i : regs_q[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else         regs_q <= regs_d;
  end

  assign rdata_o = regs_q[idx_i];
  assign chg_o   = (regs_d[REG_CTRL] != regs_q[REG_CTRL]) ||
                   (regs_d[REG_CTX]  != regs_q[REG_CTX]);

  a_r3_ctrl_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && idx_i == IDX_W'(REG_CTRL)
    |=> regs_q[REG_CTRL][DATA_W-1:2] == $past(regs_q[REG_CTRL][DATA_W-1:2]));

  a_r6_fstat_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && idx_i == IDX_W'(REG_FSTAT) && !fault_log_i |=> regs_q[REG_FSTAT] == '0);

  a_r5_faddr_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && idx_i == IDX_W'(REG_FADDR) && !fault_log_i |=> $stable(regs_q[REG_FADDR]));
endmodule

// File: rtl/mmu_flush_dec.sv
module mmu_flush_dec
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned LVL_W = 4,
  parameter int unsigned VPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic             reg_chg_i,
  output logic             flush_page_o,
  output logic [VPN_W-1:0] flush_vpn_o,
  output logic             flush_all_o
);
  logic lvl_page, lvl_all;
  assign lvl_page = (level_i == '0);
  assign lvl_all  = !lvl_page && (level_i <= LVL_W'(LVL_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_page_o <= 1'b0;
      flush_all_o  <= 1'b0;
      flush_vpn_o  <= '0;
    end else begin
      flush_page_o <= cmd_en_i && lvl_page;
      flush_all_o  <= reg_chg_i || (cmd_en_i && lvl_all);
      if (cmd_en_i && lvl_page) flush_vpn_o <= vpn_i;
    end
  end

  a_r4_chg_flushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_chg_i |=> flush_all_o);

  a_r8_high_level_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_en_i && level_i > LVL_W'(LVL_MAX) && !reg_chg_i |=> !flush_all_o && !flush_page_o);
endmodule

// File: rtl/mmu_probe_ctl.sv
module mmu_probe_ctl
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LVL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              probe_valid_i,
  output logic              probe_req_o,
  output logic [ADDR_W-1:0] probe_addr_o,
  output logic [LVL_W-1:0]  probe_level_o,
  output logic              done_o
);
  probe_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= PR_IDLE;
      probe_addr_o  <= '0;
      probe_level_o <= '0;
    end else begin
      unique case (st_q)
        PR_IDLE: if (start_i) begin
          st_q          <= PR_WAIT;
          probe_addr_o  <= addr_i;
          probe_level_o <= level_i;
        end
        PR_WAIT: if (probe_valid_i) st_q <= PR_IDLE;
        default: st_q <= PR_IDLE;
      endcase
    end
  end

  assign probe_req_o = (st_q == PR_WAIT);
  assign done_o      = probe_req_o && probe_valid_i;

  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_req_o && !probe_valid_i |=> probe_req_o && $stable(probe_addr_o) && $stable(probe_level_o));

  a_r9_req_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_req_o |-> probe_level_o <= LVL_W'(LVL_MAX));
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ASI_W-1:0]           asi_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       rvalid_o,
  output logic                       busy_o,
  output logic                       flush_page_o,
  output logic [ADDR_W-PAGE_LSB-1:0] flush_vpn_o,
  output logic                       flush_all_o,
  output logic                       probe_req_o,
  output logic [ADDR_W-1:0]          probe_addr_o,
  output logic [IDX_W-1:0]           probe_level_o,
  input  logic                       probe_valid_i,
  input  logic [DATA_W-1:0]          probe_data_i,
  input  logic                       fault_log_i,
  input  logic [DATA_W-1:0]          fault_stat_i,
  input  logic [DATA_W-1:0]          fault_addr_i
);
  localparam int unsigned VPN_W = ADDR_W - PAGE_LSB;

  logic [IDX_W-1:0]  field;
  logic              is_regs, is_maint, lvl_ok;
  logic              acc_rd, acc_wr, probe_start, probe_done;
  logic              reg_chg;
  logic [DATA_W-1:0] reg_rdata;

  assign field    = addr_i[IDX_LSB +: IDX_W];
  assign is_regs  = (asi_i == ASI_REGS);
  assign is_maint = (asi_i == ASI_MAINT);
  assign lvl_ok   = (field <= IDX_W'(LVL_MAX));

  assign acc_rd      = rd_i && !busy_o;
  assign acc_wr      = wr_i && !rd_i && !busy_o;
  assign probe_start = acc_rd && is_maint && lvl_ok;

  mmu_reg_file #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .rd_en_i      (acc_rd && is_regs),
    .wr_en_i      (acc_wr && is_regs),
    .idx_i        (field),
    .wdata_i,
    .fault_log_i, .fault_stat_i, .fault_addr_i,
    .rdata_o      (reg_rdata),
    .chg_o        (reg_chg)
  );

  mmu_flush_dec #(.LVL_W(IDX_W), .VPN_W(VPN_W)) u_flush (
    .clk_i, .rst_ni,
    .cmd_en_i     (acc_wr && is_maint),
    .level_i      (field),
    .vpn_i        (addr_i[ADDR_W-1:PAGE_LSB]),
    .reg_chg_i    (reg_chg),
    .flush_page_o, .flush_vpn_o, .flush_all_o
  );

  mmu_probe_ctl #(.ADDR_W(ADDR_W), .LVL_W(IDX_W)) u_probe (
    .clk_i, .rst_ni,
    .start_i      (probe_start),
    .addr_i,
    .level_i      (field),
    .probe_valid_i,
    .probe_req_o, .probe_addr_o, .probe_level_o,
    .done_o       (probe_done)
  );

  assign busy_o = probe_req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= (acc_rd && !probe_start) || probe_done;
      if (probe_done)             rdata_o <= probe_data_i;
      else if (acc_rd && is_regs) rdata_o <= reg_rdata;
      else if (acc_rd)            rdata_o <= '0;
    end
  end

  a_r2_reg_load_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !busy_o && is_regs |=> rvalid_o);

  a_r9_done_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_req_o && probe_valid_i |=> rvalid_o && rdata_o == $past(probe_data_i));

  a_r10_other_space_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !busy_o && !is_regs && !is_maint |=> rvalid_o && rdata_o == '0);

  a_r11_busy_no_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !flush_page_o && !flush_all_o);

  a_r8_flush_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flush_page_o, flush_all_o}));
endmodule

// File: tb/sim_mmu_ctl_regs.sv
module sim_mmu_ctl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  asi_i = '0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [31:0] rdata_o;
  logic        rvalid_o, busy_o, flush_page_o, flush_all_o, probe_req_o;
  logic [19:0] flush_vpn_o;
  logic [31:0] probe_addr_o;
  logic [3:0]  probe_level_o;
  logic        probe_valid_i = 1'b0;
  logic [31:0] probe_data_i = '0;
  logic        fault_log_i = 1'b0;
  logic [31:0] fault_stat_i = '0, fault_addr_i = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mmu_ctl_regs u0 (.*);

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit    mon_en = 1'b0;

  // reference model
  logic [31:0] m_regs [16];
  logic        m_rvalid, m_fp, m_fa, m_pend;
  logic [31:0] m_rdata, m_paddr;
  logic [19:0] m_vpn;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_regs[i]) m_regs[i] = '0;
      m_rvalid = 0; m_fp = 0; m_fa = 0; m_pend = 0;
      m_rdata = '0; m_paddr = '0; m_vpn = '0;
    end else begin
      int lv;
      logic [31:0] old;
      lv = int'(addr_i[11:8]);
      m_rvalid = 0; m_fp = 0; m_fa = 0;
      if (m_pend) begin
        if (probe_valid_i) begin m_pend = 0; m_rvalid = 1; m_rdata = probe_data_i; end
      end else if (rd_i) begin
        m_rvalid = 1;
        if (asi_i == 8'h04) begin
          m_rdata = m_regs[lv];
          if (lv == 3) m_regs[3] = '0;
        end else if (asi_i == 8'h03 && lv <= 4) begin
          m_rvalid = 0; m_pend = 1; m_paddr = addr_i;
        end else m_rdata = '0;
      end else if (wr_i) begin
        if (asi_i == 8'h04) begin
          old = m_regs[lv];
          if (lv == 0) m_regs[0] = {old[31:2], wdata_i[1:0]};
          else if (lv != 3 && lv != 4) m_regs[lv] = wdata_i;
          if ((lv == 0 || lv == 2) && old != m_regs[lv]) m_fa = 1;
        end else if (asi_i == 8'h03) begin
          if (lv == 0) begin m_fp = 1; m_vpn = addr_i[31:12]; end
          else if (lv <= 4) m_fa = 1;
        end
      end
      if (fault_log_i) begin m_regs[3] = fault_stat_i; m_regs[4] = fault_addr_i; end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) if (mon_en) begin
    chk("rvalid_o", 32'(rvalid_o), 32'(m_rvalid));
    if (m_rvalid) chk("rdata_o", rdata_o, m_rdata);
    chk("flush_page_o", 32'(flush_page_o), 32'(m_fp));
    if (m_fp) chk("flush_vpn_o", 32'(flush_vpn_o), 32'(m_vpn));
    chk("flush_all_o", 32'(flush_all_o), 32'(m_fa));
    chk("probe_req_o", 32'(probe_req_o), 32'(m_pend));
    chk("busy_o", 32'(busy_o), 32'(m_pend));
    if (m_pend) begin
      chk("probe_addr_o", probe_addr_o, m_paddr);
      chk("probe_level_o", 32'(probe_level_o), 32'(m_paddr[11:8]));
    end
  end

  task automatic acc(bit w, logic [7:0] asi, logic [31:0] a, logic [31:0] d);
    @(posedge clk_i); #1;
    asi_i = asi; addr_i = a; wdata_i = d; rd_i = !w; wr_i = w;
    @(posedge clk_i); #1;
    rd_i = 0; wr_i = 0;
  endtask

  task automatic reg_wr(int idx, logic [31:0] d); acc(1, 8'h04, 32'(idx) << 8, d); endtask
  task automatic reg_rd(int idx);                 acc(0, 8'h04, 32'(idx) << 8, '0); endtask

  // probe with walker latency; optional intruding accesses while busy
  task automatic probe(logic [31:0] a, int lat, logic [31:0] res, bit intrude);
    acc(0, 8'h03, a, '0);
    if (intrude) begin
      asi_i = 8'h04; addr_i = 32'h100; wdata_i = 32'hDEAD_BEEF; wr_i = 1;
      @(posedge clk_i); #1; wr_i = 0;
      asi_i = 8'h03; addr_i = 32'h0; rd_i = 1;
      @(posedge clk_i); #1; rd_i = 0;
    end
    repeat (lat) @(posedge clk_i);
    #1 probe_valid_i = 1; probe_data_i = res;
    @(posedge clk_i); #1 probe_valid_i = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL %s watchdog: actual hung expected done", cur_req);
    finish_run();
  end

  initial begin
    #2 mon_en = 1;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    cur_req = "R1";
    for (int i = 0; i < 16; i++) reg_rd(i);

    cur_req = "R2";
    reg_wr(1, 32'hA5A5_0F0F); reg_wr(7, 32'h1234_5678); reg_wr(15, 32'hFFFF_FFFF);
    reg_rd(1); reg_rd(7); reg_rd(15);
    acc(0, 8'h04, 32'hFFFF_F7FF, '0);   // index 7 with noise in other bits

    cur_req = "R3";
    reg_wr(0, 32'hFFFF_FFFF); reg_rd(0);
    reg_wr(0, 32'hFFFF_FFFC); reg_rd(0);
    reg_wr(0, 32'h0000_0002); reg_rd(0);

    cur_req = "R4";
    reg_wr(0, 32'h0000_0003); reg_wr(0, 32'h0000_0003);
    reg_wr(0, 32'hF000_0003);
    reg_wr(2, 32'h0000_0012); reg_wr(2, 32'h0000_0012); reg_wr(2, 32'h0000_0000);
    reg_rd(2);

    cur_req = "R5";
    reg_wr(3, 32'h1111_1111); reg_wr(4, 32'h2222_2222);
    reg_rd(3); reg_rd(4);
    reg_wr(9, 32'h0BAD_CAFE); reg_rd(9);

    cur_req = "R6";
    @(posedge clk_i); #1 fault_log_i = 1; fault_stat_i = 32'h0000_0F2C; fault_addr_i = 32'h4000_1234;
    @(posedge clk_i); #1 fault_log_i = 0;
    reg_rd(4); reg_rd(3); reg_rd(3); reg_rd(4);
    @(posedge clk_i); #1 fault_log_i = 1; fault_stat_i = 32'h55; fault_addr_i = 32'h66;
    @(posedge clk_i); #1 fault_log_i = 0;
    @(posedge clk_i); #1;
    asi_i = 8'h04; addr_i = 32'h300; rd_i = 1; fault_log_i = 1; fault_stat_i = 32'h77; fault_addr_i = 32'h88;
    @(posedge clk_i); #1 rd_i = 0; fault_log_i = 0;
    reg_rd(3); reg_rd(3); reg_rd(4);

    cur_req = "R7";
    acc(1, 8'h03, 32'hABCD_E000, '0);
    acc(1, 8'h03, 32'h0000_10FF, '0);
    acc(1, 8'h03, 32'hFFFF_F000, '0);

    cur_req = "R8";
    for (int l = 1; l < 16; l++) acc(1, 8'h03, 32'h1234_5000 | (32'(l) << 8), '0);

    cur_req = "R9";
    probe(32'h8765_4000, 0, 32'hCAFE_0001, 0);
    probe(32'h8765_4400, 3, 32'hCAFE_0004, 0);
    probe(32'h0000_0200, 1, 32'h0, 0);
    acc(0, 8'h03, 32'h0000_0500, '0);
    acc(0, 8'h03, 32'hFFFF_FFFF, '0);

    cur_req = "R10";
    acc(0, 8'h20, 32'h0000_0100, '0); acc(0, 8'h80, 32'h0, '0); acc(0, 8'h05, 32'h200, '0);
    acc(1, 8'h20, 32'h0000_0100, 32'h5555_5555); acc(1, 8'h00, 32'h0, 32'h3);
    reg_rd(1); reg_rd(0);

    cur_req = "R11";
    probe(32'h0000_0300, 4, 32'h0123_4567, 1);
    reg_rd(1);

    repeat (3) @(posedge clk_i);
    finish_run();
  end
endmodule